// File: doc/BRIEF.md
# Vector-Programmed FIFO Word Unpacker

This block sits on the transmit side of a serial engine, between the transmit FIFO and a protocol serializer. It takes one 32-bit FIFO entry at a time and hands it out one bit per output handshake. The bit order is not fixed. Up to four packing vectors, each naming a start bit, a walking direction and a run length, decide which entry bits leave and in what order. A stop flag on a vector ends the entry. Protocol words of odd size, such as 7, 15 or 23 bits, can therefore be sent most-significant or least-significant bit first.

A small write port loads the vectors and a format register. The format register holds the protocol word size and a slot granularity code. The block raises a word-end marker together with the final bit of each protocol word.

A two-state machine controls the flow. In `ST_IDLE` the entry input is ready. The *accept* transition (entry valid while idle) moves to `ST_EMIT`. In `ST_EMIT` one bit is offered per cycle. The *drain* transition (the handshake of the last bit of the final vector) returns to `ST_IDLE`. In every other case the state holds.

Top module: `fifo_bit_unpacker`

## Requirements
- R1: Configuration writes select a register with `cfg_sel` and carry the register contents in `cfg_wdata`:
  - `cfg_sel`=0 holds vector 0 in bits 9:0 and vector 1 in bits 19:10.
  - `cfg_sel`=1 holds vectors 2 and 3 in the same bit positions.
  - `cfg_sel`=2 is the format register: granularity in bits 1:0 and word size minus one in bits 6:2.
  - Within each 10-bit vector, the start index is in bits 9:5, the direction in bit 4, the run length minus one in bits 3:1 and the stop flag in bit 0.
- R2: The first bit of a vector is entry bit `start`. Each following bit of the same vector comes from the next lower index when direction is 1, or the next higher index when direction is 0. Indices wrap modulo 32.
- R3: A vector emits exactly (length field + 1) bits, from 1 to 8.
- R4: Vectors are processed in order 0, 1, 2, 3. The entry ends after the first vector whose stop flag is set. If no vector has its stop flag set, the entry ends after vector 3.
- R5: `ent_ready` is high only in `ST_IDLE`. An accepted entry produces `bit_valid` on the next cycle. `ent_ready` stays low until the entry's final bit has been handed off.
- R6: `bit_last` is high with a bit when that bit completes a protocol word. The word counter restarts at the start of each entry. The effective word size is the smaller of (word size field + 1) and the slot width, where granularity codes 0, 1 and 2 give slot widths of 8, 16 and 32 bits.
- R7: A format write whose granularity code is 3 is ignored as a whole.
- R8: Configuration writes while in `ST_EMIT` are ignored. A write in the same idle cycle as an entry acceptance applies to that entry.
- R9: While `bit_valid` is high and `bit_ready` is low, `bit_data` and `bit_last` hold their values.
- R10: After reset the block is idle (`ent_ready`=1, `bit_valid`=0). The vectors reset to 8-bit slots sent least-significant bit first: starts 0, 8, 16, 24, direction 0, length field 7, stop flag on vector 3 only. The word size resets to 8 and the granularity to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | 1 | FIFO entry offered |
| ent_ready | output | 1 | Entry accepted this cycle when valid |
| ent_data | input | 32 | FIFO entry contents |
| bit_valid | output | 1 | Output bit present |
| bit_ready | input | 1 | Serializer takes the bit |
| bit_data | output | 1 | Output bit |
| bit_last | output | 1 | Bit closes a protocol word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 vectors 0/1, 1 vectors 2/3, 2 format |
| cfg_wdata | input | 20 | Write data |

## Verification
A configuration write and an entry acceptance can happen in the same idle cycle, because both are decided at one clock edge. The bench raises `cfg_we` with a new vector layout and `ent_valid` in the same cycle. It expects the resulting bit stream to follow the new layout. It also issues a write one cycle into emission and expects both the current entry and the following entry to keep the old layout. Output stalls from a periodic `bit_ready` pattern coincide with vector and word boundaries. The bench checks that the bit and its marker hold through each stall.

// File: rtl/upk_pkg.sv
package upk_pkg;
    localparam int ENTRY_W = 32;
    localparam int POS_W   = $clog2(ENTRY_W);
    localparam int LEN_W   = 3;
    localparam int VEC_W   = POS_W + 1 + LEN_W + 1;
    localparam int NVEC    = 4;
    localparam int VI_W    = $clog2(NVEC);
    localparam int NREG    = NVEC / 2;
    localparam int CFG_W   = 2 * VEC_W;
    localparam int GRAN_W  = 2;
    localparam int SEL_W   = 2;
    localparam int CNT_W   = POS_W + 1;

    // field order mirrors the bit positions of a packing vector
    typedef struct packed {
        logic [POS_W-1:0] start;
        logic             walk_down;
        logic [LEN_W-1:0] run_m1;
        logic             last_vec;
    } vec_t;

    typedef enum logic {ST_IDLE, ST_EMIT} state_t;

    function automatic vec_t default_vec(input int i);
        vec_t v;
        v.start     = POS_W'(8 * i);
        v.walk_down = 1'b0;
        v.run_m1    = '1;
        v.last_vec  = (i == NVEC - 1);
        return v;
    endfunction
endpackage

// File: rtl/upk_cfg_regs.sv
module upk_cfg_regs
    import upk_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        sel,
    input  logic [CFG_W-1:0]        wdata,
    output vec_t [NVEC-1:0]         vecs,
    output logic [GRAN_W-1:0]       gran,
    output logic [POS_W-1:0]        wbits_m1
);
    localparam logic [SEL_W-1:0] FMT_SEL = SEL_W'(NREG);

    for (genvar r = 0; r < NREG; r++) begin : g_vreg
        logic [CFG_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= {default_vec(2*r+1), default_vec(2*r)};
            else if (wr_en && sel == SEL_W'(r))
                word_q <= wdata;
        end
        assign vecs[2*r]   = vec_t'(word_q[VEC_W-1:0]);
        assign vecs[2*r+1] = vec_t'(word_q[CFG_W-1:VEC_W]);
    end

    // format register: a reserved granularity code drops the whole write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gran     <= '0;
            wbits_m1 <= POS_W'(7);
        end else if (wr_en && sel == FMT_SEL && wdata[GRAN_W-1:0] != 2'd3) begin
            gran     <= wdata[GRAN_W-1:0];
            wbits_m1 <= wdata[GRAN_W+POS_W-1:GRAN_W];
        end
    end
endmodule

// File: rtl/upk_cursor.sv
module upk_cursor
    import upk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  vec_t [NVEC-1:0]   vecs,
    output logic [POS_W-1:0]  pos_o,
    output logic              final_o
);
    logic [VI_W-1:0]  vidx;
    logic [LEN_W-1:0] run;
    logic [POS_W-1:0] walk_q;
    vec_t             cur;
    logic             run_end;

    assign cur     = vecs[vidx];
    assign run_end = (run == cur.run_m1);
    // first bit of a run comes straight from the vector, so a write that
    // lands with the entry acceptance is honoured
    assign pos_o   = (run == '0) ? cur.start : walk_q;
    assign final_o = run_end && (cur.last_vec || vidx == VI_W'(NVEC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            vidx   <= '0;
            run    <= '0;
            walk_q <= '0;
        end else if (step_i) begin
            if (run_end) begin
                vidx <= vidx + 1'b1;
                run  <= '0;
            end else begin
                run    <= run + 1'b1;
                walk_q <= cur.walk_down ? pos_o - 1'b1 : pos_o + 1'b1;
            end
        end
    end

    // R3: the run counter never passes the programmed length
    a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run <= cur.run_m1);
endmodule

// File: rtl/upk_word_track.sv
module upk_word_track
    import upk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [GRAN_W-1:0] gran,
    input  logic [POS_W-1:0]  wbits_m1,
    output logic              word_end
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wsize;
    logic [CNT_W-1:0] slot;
    logic [CNT_W-1:0] eff;

    assign wsize    = {1'b0, wbits_m1} + 1'b1;
    assign slot     = CNT_W'(8) << gran;
    assign eff      = (wsize < slot) ? wsize : slot;
    assign word_end = (cnt + 1'b1 == eff);

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            cnt <= '0;
        else if (step_i)
            cnt <= word_end ? '0 : cnt + 1'b1;
    end

    // R6: a counted bit always lies inside the current word
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> cnt < eff);
endmodule

// File: rtl/fifo_bit_unpacker.sv
module fifo_bit_unpacker
    import upk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ent_valid,
    output logic                ent_ready,
    input  logic [ENTRY_W-1:0]  ent_data,
    output logic                bit_valid,
    input  logic                bit_ready,
    output logic                bit_data,
    output logic                bit_last,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata
);
    state_t               state;
    logic [ENTRY_W-1:0]   data_q;
    vec_t [NVEC-1:0]      vecs;
    logic [GRAN_W-1:0]    gran;
    logic [POS_W-1:0]     wbits_m1;
    logic [POS_W-1:0]     pos;
    logic                 final_bit;
    logic                 word_end;
    logic                 accept;
    logic                 step;

    assign accept = ent_valid && ent_ready;
    assign step   = bit_valid && bit_ready;

    upk_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && state == ST_IDLE),
        .sel(cfg_sel), .wdata(cfg_wdata),
        .vecs(vecs), .gran(gran), .wbits_m1(wbits_m1)
    );

    upk_cursor u_cur (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .step_i(step),
        .vecs(vecs), .pos_o(pos), .final_o(final_bit)
    );

    upk_word_track u_word (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .step_i(step),
        .gran(gran), .wbits_m1(wbits_m1), .word_end(word_end)
    );

    // state register: accept and drain transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            data_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (ent_valid) begin
                    state  <= ST_EMIT;
                    data_q <= ent_data;
                end
                ST_EMIT: if (step && final_bit) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ent_ready = 1'b0;
        bit_valid = 1'b0;
        unique case (state)
            ST_IDLE: ent_ready = 1'b1;
            ST_EMIT: bit_valid = 1'b1;
            default: ent_ready = 1'b0;
        endcase
        bit_data = data_q[pos];
        bit_last = word_end;
    end

    // R5: an accepted entry starts emission and closes the input
    a_r5_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> bit_valid && !ent_ready);
    // R4: the final bit of an entry returns the block to idle
    a_r4_final_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (step && final_bit) |=> ent_ready);
    // R8: configuration is frozen while emitting
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |=> $stable(vecs) && $stable(gran) && $stable(wbits_m1));
    // R9: a stalled bit and its marker hold
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_ready) |=> bit_valid && $stable(bit_data) && $stable(bit_last));
endmodule

// File: tb/fifo_bit_unpacker_test.sv
module fifo_bit_unpacker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ent_valid = 1'b0;
    logic        ent_ready;
    logic [31:0] ent_data = '0;
    logic        bit_valid;
    logic        bit_ready;
    logic        bit_data;
    logic        bit_last;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [19:0] cfg_wdata = '0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    string cur_req = "R10";

    logic [9:0] mv [4];
    int mwb = 8;
    int mg = 0;
    logic [1:0] exp_q [$];

    fifo_bit_unpacker uut (
        .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_ready(ent_ready),
        .ent_data(ent_data), .bit_valid(bit_valid), .bit_ready(bit_ready),
        .bit_data(bit_data), .bit_last(bit_last), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] mkvec(input int st, input bit dn, input int lm1, input bit stp);
        return {5'(st), dn, 3'(lm1), stp};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) bit_ready <= 1'b1;
        else bit_ready <= stall_mode ? (cyc % 3 != 0) : 1'b1;
        if (cyc == 20000) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // scoreboard monitor and stall check
    logic       hold_pend = 1'b0;
    logic [1:0] hold_val = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend)
                chk(bit_valid && {bit_data, bit_last} == hold_val, "R9 stall hold",
                    {31'd0, bit_data}, {31'd0, hold_val[1]});
            hold_pend = bit_valid && !bit_ready;
            hold_val  = {bit_data, bit_last};
            if (bit_valid && bit_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_req, " unexpected bit"}, 32'd1, 32'd0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    chk({bit_data, bit_last} == e, cur_req, {30'd0, bit_data, bit_last}, {30'd0, e});
                end
            end
        end
    end

    task automatic mirror_apply(input logic [1:0] s, input logic [19:0] w);
        if (s == 2'd0) begin mv[0] = w[9:0]; mv[1] = w[19:10]; end
        else if (s == 2'd1) begin mv[2] = w[9:0]; mv[3] = w[19:10]; end
        else if (s == 2'd2 && w[1:0] != 2'd3) begin mg = int'(w[1:0]); mwb = int'(w[6:2]) + 1; end
    endtask

    task automatic push_expected(input logic [31:0] d);
        int wc;
        int ws;
        int p;
        bit lst;
        wc = 0;
        ws = (mwb < (8 << mg)) ? mwb : (8 << mg);
        for (int i = 0; i < 4; i++) begin
            p = int'(mv[i][9:5]);
            for (int k = 0; k <= int'(mv[i][3:1]); k++) begin
                wc++;
                lst = (wc == ws);
                if (lst) wc = 0;
                exp_q.push_back({d[p], lst});
                p = mv[i][4] ? ((p + 31) % 32) : ((p + 1) % 32);
            end
            if (mv[i][0]) break;
        end
    endtask

    task automatic wr_idle(input logic [1:0] s, input logic [19:0] w, input bit apply);
        while (!ent_ready) @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = w;
        if (apply) mirror_apply(s, w);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] d, input bit wr, input logic [1:0] s, input logic [19:0] w);
        while (!ent_ready) @(negedge clk);
        ent_valid = 1'b1; ent_data = d;
        if (wr) begin
            cfg_we = 1'b1; cfg_sel = s; cfg_wdata = w;
            mirror_apply(s, w);
        end
        push_expected(d);
        @(negedge clk);
        ent_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !ent_ready) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mv[i] = mkvec(8 * i, 1'b0, 7, i == 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ent_ready == 1'b1, "R10 idle ready", {31'd0, ent_ready}, 32'd1);
        chk(bit_valid == 1'b0, "R10 no output", {31'd0, bit_valid}, 32'd0);

        cur_req = "R10 default layout";
        send(32'hA5C3_1E7F, 1'b0, 2'd0, '0);
        drain();

        cur_req = "R1 R2 R3 R6 7-bit msb-first";
        wr_idle(2'd0, {mkvec(14, 1, 6, 0), mkvec(6, 1, 6, 0)}, 1'b1);
        wr_idle(2'd1, {mkvec(30, 1, 6, 1), mkvec(22, 1, 6, 0)}, 1'b1);
        wr_idle(2'd2, {13'd0, 5'd6, 2'd0}, 1'b1);
        send(32'h1234_5678, 1'b0, 2'd0, '0);
        send(32'hFEDC_BA98, 1'b0, 2'd0, '0);
        drain();

        cur_req = "R2 R4 R9 23-bit msb-first stalled";
        stall_mode = 1'b1;
        wr_idle(2'd0, {mkvec(14, 1, 7, 0), mkvec(22, 1, 7, 0)}, 1'b1);
        wr_idle(2'd1, {mkvec(0, 1, 0, 0), mkvec(6, 1, 6, 1)}, 1'b1);
        wr_idle(2'd2, {13'd0, 5'd22, 2'd2}, 1'b1);
        send(32'h0055_AA33, 1'b0, 2'd0, '0);
        send(32'h7F00_81C6, 1'b0, 2'd0, '0);
        drain();

        cur_req = "R2 R3 R6 15-bit lsb-first";
        wr_idle(2'd0, {mkvec(8, 0, 6, 0), mkvec(0, 0, 7, 0)}, 1'b1);
        wr_idle(2'd1, {mkvec(24, 0, 6, 1), mkvec(16, 0, 7, 0)}, 1'b1);
        wr_idle(2'd2, {13'd0, 5'd14, 2'd1}, 1'b1);
        send(32'hC0DE_F00D, 1'b0, 2'd0, '0);
        drain();

        cur_req = "R6 slot caps word size";
        wr_idle(2'd2, {13'd0, 5'd15, 2'd0}, 1'b1);
        send(32'h8421_3C5A, 1'b0, 2'd0, '0);
        drain();

        cur_req = "R4 no stop flag runs to vector 3";
        stall_mode = 1'b0;
        wr_idle(2'd0, {mkvec(1, 1, 2, 0), mkvec(30, 0, 3, 0)}, 1'b1);
        wr_idle(2'd1, {mkvec(12, 1, 4, 0), mkvec(20, 0, 1, 0)}, 1'b1);
        wr_idle(2'd2, {13'd0, 5'd4, 2'd0}, 1'b1);
        send(32'h9B3D_E271, 1'b0, 2'd0, '0);
        drain();

        cur_req = "R7 reserved granularity ignored";
        wr_idle(2'd2, {13'd0, 5'd2, 2'd3}, 1'b1);
        send(32'h6E5A_0F93, 1'b0, 2'd0, '0);
        drain();

        cur_req = "R8 write while emitting ignored";
        send(32'h2468_ACE1, 1'b0, 2'd0, '0);
        chk(ent_ready == 1'b0, "R5 busy after accept", {31'd0, ent_ready}, 32'd0);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = {mkvec(3, 1, 0, 1), mkvec(3, 1, 0, 1)};
        @(negedge clk);
        cfg_we = 1'b0;
        drain();
        send(32'h1357_9BDF, 1'b0, 2'd0, '0);
        drain();

        cur_req = "R8 write with acceptance applies";
        send(32'h0F0F_3355, 1'b1, 2'd0, {mkvec(9, 0, 2, 0), mkvec(27, 1, 5, 1)});
        drain();

        chk(exp_q.size() == 0, "R4 all expected bits seen", exp_q.size(), 32'd0);
        chk(ent_ready == 1'b1 && bit_valid == 1'b0, "R5 idle at end",
            {30'd0, ent_ready, bit_valid}, 32'd2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule